// File: doc/BRIEF.md
# Pointer-Addressed Packet Data Port

This block gives a host byte-wide access into a packet memory split into four pages of 2048 bytes each. The host loads a 16-bit pointer through two byte registers, then reads or writes packet bytes through a four-byte data window. Two pointer bits decide how each window access is resolved. Bit 15 picks the page: either the page named by the packet number input or the page at the head of the receive queue. Bit 14 picks the addressing mode: either the pointer stepping forward after every data access, or a fixed pointer plus the window byte offset.

Host requests enter on a valid/ready channel. A request moves when `req_valid` and `req_ready` are both high on a clock edge. Only reads return data. Each accepted read produces exactly one response on a valid/ready channel one cycle later. While a response is waiting with `rsp_ready` low, `req_ready` is held low, so at most one read result is ever in flight. The response byte stays stable until it is taken. Writes complete on acceptance and produce no response.

Top module: `pkt_data_port`

## Requirements
- R1: After reset the pointer is zero, so reads of offsets 6 and 7 return 0x00.
- R2: A write to offset 6 loads pointer bits [7:0] and a write to offset 7 loads bits [15:8]. A read of offset 6 returns bits [7:0]. A read of offset 7 returns bits [15:8] ANDed with 0xF7, so bit 11 always reads as 0.
- R3: Data accesses (offsets 8 to 11) go to the page on `rxq_head` when pointer bit 15 is 1, and to the page on `pkt_num` when it is 0.
- R4: With pointer bit 14 at 0, a data access at offset 8+k uses byte address (pointer[10:0] + k) mod 2048 and leaves the pointer unchanged.
- R5: With pointer bit 14 at 1, a data access uses byte address pointer[10:0] whatever the window offset. Afterwards pointer[10:0] advances by one modulo 2048 and pointer[15:11] keep their value.
- R6: Auto-increment is triggered by data reads as well as data writes. A read returns the byte at the address in use before the increment.
- R7: A read accepted on one edge raises `rsp_valid` on the next edge. While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and `rsp_rdata` holds its value. A write never raises `rsp_valid`.
- R8: Writes to offsets other than 6 to 11 change nothing. Reads of those offsets return 0x00.
- R9: A byte written through the data window is returned by a later read of the same page and byte address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 4 | Byte offset of the access |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Host takes the read result |
| rsp_rdata | output | 8 | Read result byte |
| pkt_num | input | 2 | Page chosen by the packet number register |
| rxq_head | input | 2 | Page at the head of the receive queue |

## Verification
The bench uses data written into different pages at the same byte address. A design that ignored bit 15 would return the wrong page's byte. It steps the pointer across the 2047-to-0 boundary in both modes. A carry leaking into bit 11 or above would show up in the high pointer byte. A window read that wrapped wrongly would fetch a byte other than the one planted at address 0. Reads of offset 6 taken between auto-increment accesses catch a design that advanced only on writes, or that returned the byte after the step. A stalled response, with a second read held on the request channel, catches a result that was overwritten or a request that was accepted early.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  localparam logic [3:0] OFF_PTR_LO = 4'd6;
  localparam logic [3:0] OFF_PTR_HI = 4'd7;
  localparam int         PTR_W      = 16;
  localparam int         BIT_RXSEL  = 15;
  localparam int         BIT_AUTO   = 14;
  localparam logic [7:0] HI_RD_MASK = 8'hF7;

  function automatic logic in_window(input logic [3:0] off);
    return off[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/pdp_ptr_reg.sv
module pdp_ptr_reg #(
  parameter int ADDR_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [7:0]  wdata,
  input  logic        step,
  output logic [15:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_lo) begin
      ptr[7:0] <= wdata;
    end else if (wr_hi) begin
      ptr[15:8] <= wdata;
    end else if (step) begin
      ptr[ADDR_W-1:0] <= ptr[ADDR_W-1:0] + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/pdp_addr_gen.sv
module pdp_addr_gen #(
  parameter int PAGE_W = 2,
  parameter int ADDR_W = 11
) (
  input  logic [15:0]       ptr,
  input  logic [1:0]        lane,
  input  logic [PAGE_W-1:0] pkt_num,
  input  logic [PAGE_W-1:0] rxq_head,
  output logic [PAGE_W-1:0] page,
  output logic [ADDR_W-1:0] byte_addr,
  output logic              auto_inc
);
  import pdp_pkg::*;

  always_comb begin
    auto_inc = ptr[BIT_AUTO];
    page     = ptr[BIT_RXSEL] ? rxq_head : pkt_num;
    if (auto_inc) byte_addr = ptr[ADDR_W-1:0];
    else          byte_addr = ptr[ADDR_W-1:0] + ADDR_W'(lane);
  end
endmodule

// File: rtl/pdp_ram.sv
module pdp_ram #(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 2048,
  parameter int WORD_BYTES = 4,
  localparam int PAGE_W    = $clog2(PAGES),
  localparam int ADDR_W    = $clog2(PAGE_BYTES),
  localparam int LANE_W    = $clog2(WORD_BYTES),
  localparam int WORDS     = PAGES * PAGE_BYTES / WORD_BYTES,
  localparam int IDX_W     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [8*WORD_BYTES-1:0] mem [WORDS];
  logic [8*WORD_BYTES-1:0] q_word;
  logic [LANE_W-1:0]       q_lane;
  logic [IDX_W-1:0]        idx;
  logic [LANE_W-1:0]       lane;
  logic [WORD_BYTES-1:0]   lane_we;

  assign idx  = {page, byte_addr[ADDR_W-1:LANE_W]};
  assign lane = byte_addr[LANE_W-1:0];

  for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
    assign lane_we[l] = wr_en && (lane == LANE_W'(l));
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < WORD_BYTES; l++) begin
      if (lane_we[l]) mem[idx][8*l +: 8] <= wdata;
    end
    if (rd_en) begin
      q_word <= mem[idx];
      q_lane <= lane;
    end
  end

  assign rdata = q_word[8*q_lane +: 8];
endmodule

// File: rtl/pkt_data_port.sv
module pkt_data_port #(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 2048,
  parameter int WORD_BYTES = 4,
  localparam int PAGE_W    = $clog2(PAGES),
  localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [3:0]        req_offset,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_rdata,
  input  logic [PAGE_W-1:0] pkt_num,
  input  logic [PAGE_W-1:0] rxq_head
);
  import pdp_pkg::*;

  logic              acc, rd_acc, data_acc;
  logic              wr_lo, wr_hi, step;
  logic [15:0]       ptr_q;
  logic [PAGE_W-1:0] page;
  logic [ADDR_W-1:0] byte_addr;
  logic              auto_inc;
  logic [7:0]        ram_rdata;
  logic              from_ram_q;
  logic [7:0]        reg_byte_q;
  logic [7:0]        reg_byte_d;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign rd_acc    = acc && !req_write;
  assign data_acc  = acc && in_window(req_offset);
  assign wr_lo     = acc && req_write && (req_offset == OFF_PTR_LO);
  assign wr_hi     = acc && req_write && (req_offset == OFF_PTR_HI);
  assign step      = data_acc && auto_inc;

  pdp_ptr_reg #(.ADDR_W(ADDR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (req_wdata),
    .step  (step),
    .ptr   (ptr_q)
  );

  pdp_addr_gen #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_addr (
    .ptr       (ptr_q),
    .lane      (req_offset[1:0]),
    .pkt_num   (pkt_num),
    .rxq_head  (rxq_head),
    .page      (page),
    .byte_addr (byte_addr),
    .auto_inc  (auto_inc)
  );

  pdp_ram #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(WORD_BYTES)) u_ram (
    .clk       (clk),
    .rd_en     (data_acc && !req_write),
    .wr_en     (data_acc && req_write),
    .page      (page),
    .byte_addr (byte_addr),
    .wdata     (req_wdata),
    .rdata     (ram_rdata)
  );

  always_comb begin
    case (req_offset)
      OFF_PTR_LO: reg_byte_d = ptr_q[7:0];
      OFF_PTR_HI: reg_byte_d = ptr_q[15:8] & HI_RD_MASK;
      default:    reg_byte_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      from_ram_q <= 1'b0;
      reg_byte_q <= 8'h00;
    end else if (rd_acc) begin
      rsp_valid  <= 1'b1;
      from_ram_q <= in_window(req_offset);
      reg_byte_q <= reg_byte_d;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  assign rsp_rdata = from_ram_q ? ram_rdata : reg_byte_q;
endmodule

// File: rtl/pdp_checker.sv
module pdp_checker #(
  parameter int ADDR_W = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [3:0]  req_offset,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [7:0]  rsp_rdata,
  input logic [15:0] ptr
);
  logic acc, win;
  assign acc = req_valid && req_ready;
  assign win = req_offset[3:2] == 2'b10;

  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_read_answers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid);

  p_write_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !rsp_valid) |=> !rsp_valid);

  p_step_wraps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && win && ptr[14]) |=>
      ((ptr[ADDR_W-1:0] == $past(ptr[ADDR_W-1:0]) + ADDR_W'(1)) &&
       (ptr[15:ADDR_W] == $past(ptr[15:ADDR_W]))));

  p_window_keeps_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && win && !ptr[14]) |=> $stable(ptr));

  p_hi_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_offset == 4'd7) |=> (rsp_rdata[3] == 1'b0));
endmodule

bind pkt_data_port pdp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_offset (req_offset),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .ptr        (ptr_q)
);

// File: tb/tb_pkt_data_port.sv
`timescale 1ns/1ps
module tb_pkt_data_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [3:0] req_offset = 4'd0;
  logic [7:0] req_wdata = 8'h00;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_rdata;
  logic [1:0] pkt_num = 2'd1;
  logic [1:0] rxq_head = 2'd2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pkt_data_port dut (.*);

  // {req[3:0], write, offset[3:0], wdata[7:0], expected[7:0]}
  localparam int NV = 43;
  localparam logic [24:0] VEC [NV] = '{
    {4'd2, 1'b1, 4'd6,  8'h10, 8'h00},  // R2 low byte
    {4'd2, 1'b1, 4'd7,  8'h40, 8'h00},  // R2 high byte, auto mode
    {4'd5, 1'b1, 4'd8,  8'hAA, 8'h00},  // R5 addr 0x10
    {4'd5, 1'b1, 4'd9,  8'hBB, 8'h00},  // R5 addr 0x11, offset ignored
    {4'd5, 1'b1, 4'd10, 8'hCC, 8'h00},  // R5 addr 0x12
    {4'd5, 1'b0, 4'd6,  8'h00, 8'h13},  // R5 stepped three times
    {4'd5, 1'b0, 4'd7,  8'h00, 8'h40},  // R5 upper bits kept
    {4'd2, 1'b1, 4'd6,  8'h10, 8'h00},
    {4'd2, 1'b1, 4'd7,  8'h00, 8'h00},  // window mode, page pkt_num
    {4'd9, 1'b0, 4'd8,  8'h00, 8'hAA},  // R9 round trip
    {4'd4, 1'b0, 4'd9,  8'h00, 8'hBB},  // R4 ptr+1
    {4'd4, 1'b0, 4'd10, 8'h00, 8'hCC},  // R4 ptr+2
    {4'd4, 1'b0, 4'd6,  8'h00, 8'h10},  // R4 pointer unchanged
    {4'd8, 1'b1, 4'd12, 8'h55, 8'h00},  // R8 ignored write
    {4'd8, 1'b0, 4'd12, 8'h00, 8'h00},  // R8 reads zero
    {4'd8, 1'b0, 4'd6,  8'h00, 8'h10},  // R8 pointer untouched
    {4'd8, 1'b0, 4'd13, 8'h00, 8'h00},  // R8
    {4'd2, 1'b1, 4'd7,  8'hFF, 8'h00},  // ptr 0xFF10
    {4'd2, 1'b0, 4'd7,  8'h00, 8'hF7},  // R2 mask
    {4'd3, 1'b1, 4'd8,  8'h77, 8'h00},  // R3 page rxq_head addr 0x710
    {4'd6, 1'b0, 4'd6,  8'h00, 8'h11},  // R6 write stepped
    {4'd6, 1'b1, 4'd6,  8'h10, 8'h00},
    {4'd6, 1'b0, 4'd8,  8'h00, 8'h77},  // R6 pre-increment byte
    {4'd6, 1'b0, 4'd6,  8'h00, 8'h11},  // R6 read stepped
    {4'd3, 1'b1, 4'd6,  8'h10, 8'h00},
    {4'd3, 1'b1, 4'd7,  8'h07, 8'h00},  // ptr 0x0710, page pkt_num
    {4'd3, 1'b1, 4'd8,  8'h33, 8'h00},
    {4'd3, 1'b0, 4'd8,  8'h00, 8'h33},  // R3 pkt_num page
    {4'd3, 1'b1, 4'd7,  8'h87, 8'h00},  // ptr 0x8710
    {4'd3, 1'b0, 4'd8,  8'h00, 8'h77},  // R3 rxq_head page
    {4'd5, 1'b1, 4'd6,  8'hFF, 8'h00},
    {4'd5, 1'b1, 4'd7,  8'h47, 8'h00},  // ptr 0x47FF
    {4'd5, 1'b1, 4'd11, 8'h5A, 8'h00},  // addr 0x7FF then wrap
    {4'd5, 1'b0, 4'd7,  8'h00, 8'h40},  // R5 no carry into bit 11
    {4'd5, 1'b0, 4'd6,  8'h00, 8'h00},  // R5 wrapped to 0
    {4'd4, 1'b1, 4'd8,  8'h6C, 8'h00},  // addr 0
    {4'd4, 1'b1, 4'd6,  8'hFE, 8'h00},
    {4'd4, 1'b1, 4'd7,  8'h07, 8'h00},  // ptr 0x07FE
    {4'd4, 1'b0, 4'd9,  8'h00, 8'h5A},  // R4 addr 0x7FF
    {4'd4, 1'b1, 4'd6,  8'hFF, 8'h00},
    {4'd4, 1'b0, 4'd9,  8'h00, 8'h6C},  // R4 window wraps to 0
    {4'd4, 1'b0, 4'd6,  8'h00, 8'hFF},
    {4'd4, 1'b0, 4'd7,  8'h00, 8'h07}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_offset = off; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] off, output logic [7:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_offset = off;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %h expected %h", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 req_ready", {7'd0, req_ready}, 8'h01);
    check("R1 rsp_valid", {7'd0, rsp_valid}, 8'h00);
    do_read(4'd6, d, v); check("R1 ptr lo", d, 8'h00);
    do_read(4'd7, d, v); check("R1 ptr hi", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        do_write(VEC[i][19:16], VEC[i][15:8]);
      end else begin
        do_read(VEC[i][19:16], d, v);
        check($sformatf("R%0d step %0d valid", VEC[i][24:21], i), {7'd0, v}, 8'h01);
        check($sformatf("R%0d step %0d", VEC[i][24:21], i), d, VEC[i][7:0]);
      end
    end

    // R7 a write leaves no response
    do_write(4'd6, 8'h3C);
    check("R7 write no rsp", {7'd0, rsp_valid}, 8'h00);
    do_write(4'd7, 8'h02);

    // R7 back-pressure with a second read waiting
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_offset = 4'd6;
    @(posedge clk);
    @(negedge clk);
    check("R7 rsp raised", {7'd0, rsp_valid}, 8'h01);
    check("R7 first data", rsp_rdata, 8'h3C);
    req_offset = 4'd7;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 ready low", {7'd0, req_ready}, 8'h00);
      check("R7 held data", rsp_rdata, 8'h3C);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 second valid", {7'd0, rsp_valid}, 8'h01);
    check("R7 second data", rsp_rdata, 8'h02);
    @(negedge clk);
    check("R7 drained", {7'd0, rsp_valid}, 8'h00);

    // R1 reset in mid-run clears the pointer
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_read(4'd6, d, v); check("R1 mid reset lo", d, 8'h00);
    do_read(4'd7, d, v); check("R1 mid reset hi", d, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule